// File: doc/BRIEF.md
# Sectored Direct-Mapped Write-Back Cache Controller

This block holds the tag and per-quad state of a direct-mapped, write-back, write-allocate cache. Each line is divided into quads of `WPQ` words, and each quad is filled, dirtied and tracked on its own. A processor-side access carries a word address, a read/write flag and a flag marking it as the target of a jump. The controller looks up the line and reports the outcome as a hit, a quad miss or a line miss. It then drives the next memory level through a single valid/ready command port.

On a line miss, the controller first writes back each dirty quad of the victim line, one command per quad, lowest quad first. It then fetches the accessed address, so only the touched quad is refilled. On a quad miss inside a resident line, it issues just that one fetch. Nine saturating event counters record the traffic, and any one of them can be read through a select input. A flush input drops every line without writing anything back and keeps the counters. Reset does the same and also zeroes the counters. `LINES`, `QUADS` and `WPQ` must be powers of two, with `LINES` at least 2 and `QUADS` at most 64.

The control state machine has four states. `ST_IDLE` accepts accesses and flushes. `ST_LOOKUP` reads the indexed entry and classifies the access. `ST_WRITEBACK` drains the victim's dirty quads. `ST_FILL` issues the single fetch. The transitions are:
- accept: `ST_IDLE` to `ST_LOOKUP`
- hit: `ST_LOOKUP` to `ST_IDLE`
- quad miss: `ST_LOOKUP` to `ST_FILL`
- line miss: `ST_LOOKUP` to `ST_WRITEBACK`
- drained: `ST_WRITEBACK` to `ST_FILL`, once no dirty quad remains
- filled: `ST_FILL` to `ST_IDLE`, when the fetch is accepted

Top module: `sdm_cache_ctl`

## Requirements
- R1: A word address splits, from the least significant bit upward, into the word-in-quad field (log2 WPQ bits), the quad index (log2 QUADS bits), the line index (log2 LINES bits) and the tag (the remaining bits). An access hits a line only when the indexed entry is valid and its stored tag equals the access tag, so lines with different indices never disturb each other.
- R2: An access to a resident line whose quad is present issues no memory command and answers with `rsp_kind` = 0.
- R3: When the line is resident but the quad is not present, the controller issues exactly one read command (`mem_write` = 0) at the accessed address, marks the quad present and answers with `rsp_kind` = 1.
- R4: On a line miss, the controller first issues one write command (`mem_write` = 1) for each dirty quad of the victim line, in ascending quad order, at victim tag/index with quad offset q×WPQ. It then issues one read command at the accessed address and answers with `rsp_kind` = 2.
- R5: After a line miss, the entry holds the new tag, only the accessed quad is present, and no earlier dirty state remains.
- R6: A write marks its quad dirty whether it hit or missed, and a write miss allocates the line or quad exactly like a read miss.
- R7: `rsp_first_touch` is 1 when the quad had not been referenced since its line was allocated, and 0 otherwise. Every access marks its quad referenced.
- R8: `acc_ready` is low from the cycle after an access is accepted until its response. At most one memory command is outstanding, and `mem_write`/`mem_addr` hold steady while `mem_valid` is high and `mem_ready` is low.
- R9: `stat_sel` selects the counters with these codes: 0 probes, 1 reads, 2 writes, 3 write misses, 4 writes to a clean quad, 5 quad misses, 6 line misses, 7 misses flagged as jumps, 8 dirty-quad write-backs. Other codes read 0.
- R10: Each counter stops at its all-ones value and never decreases except at reset.
- R11: A `flush_req` pulse taken in `ST_IDLE` invalidates all lines and clears their per-quad bits with no write-back, and it leaves the counters unchanged. `acc_ready` is low while `flush_req` is high.
- R12: After reset, all lines are invalid, every counter reads 0, `acc_ready` is 1, and `mem_valid` and `rsp_valid` are 0.
- R13: `rsp_valid` is a one-cycle pulse per access. `rsp_kind` takes only the values 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_req | input | 1 | Invalidate all lines, no write-back |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Controller can take an access |
| acc_addr | input | AW | Word address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_jump | input | 1 | Access is the target of a jump |
| rsp_valid | output | 1 | Access outcome pulse |
| rsp_kind | output | 2 | 0 hit, 1 quad miss, 2 line miss |
| rsp_first_touch | output | 1 | Quad not referenced before |
| mem_valid | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory command accepted |
| mem_write | output | 1 | 1 = quad write-back, 0 = fetch |
| mem_addr | output | AW | Command word address |
| stat_sel | input | SELW | Counter select |
| stat_value | output | CNT_W | Selected counter value |

## Verification
Directed sequences exercise each way an access can resolve. They run a cold line miss, a hit on the same quad, a quad miss in a resident line, and a conflict miss on a line with three of four quads dirty. A bad write-back order or offset shows up only in that conflict case. Accesses to neighbouring line indices separate index decoding from tag comparison. A dirty line followed by a flush separates invalidation from write-back. A long seeded random mix over a four-tag window produces all three outcomes and frequent conflicts, with randomly stalled memory acceptance. It drives the probe counter past its limit, so the saturation logic is checked against the normal increment path.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRITEBACK,
        ST_FILL
    } sdm_state_e;

    localparam logic [1:0] KIND_HIT  = 2'd0;
    localparam logic [1:0] KIND_QUAD = 2'd1;
    localparam logic [1:0] KIND_LINE = 2'd2;

    localparam int NUM_STATS   = 9;
    localparam int ST_PROBE    = 0;
    localparam int ST_READ     = 1;
    localparam int ST_WRITE    = 2;
    localparam int ST_WMISS    = 3;
    localparam int ST_WCLEAN   = 4;
    localparam int ST_QMISS    = 5;
    localparam int ST_LMISS    = 6;
    localparam int ST_JMISS    = 7;
    localparam int ST_WBACK    = 8;

endpackage

// File: rtl/sdm_line_store.sv
module sdm_line_store #(
    parameter int LINES = 16,
    parameter int QUADS = 4,
    parameter int TAGW  = 8,
    localparam int IDXW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_all,
    input  logic [IDXW-1:0]  rd_idx,
    output logic             rd_valid,
    output logic [TAGW-1:0]  rd_tag,
    output logic [QUADS-1:0] rd_present,
    output logic [QUADS-1:0] rd_dirty,
    output logic [QUADS-1:0] rd_ref,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [TAGW-1:0]  wr_tag,
    input  logic [QUADS-1:0] wr_present,
    input  logic [QUADS-1:0] wr_dirty,
    input  logic [QUADS-1:0] wr_ref
);

    logic [LINES-1:0]            valid_w;
    logic [LINES-1:0][TAGW-1:0]  tag_w;
    logic [LINES-1:0][QUADS-1:0] pres_w;
    logic [LINES-1:0][QUADS-1:0] dirty_w;
    logic [LINES-1:0][QUADS-1:0] ref_w;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic             v_q;
        logic [TAGW-1:0]  t_q;
        logic [QUADS-1:0] p_q;
        logic [QUADS-1:0] d_q;
        logic [QUADS-1:0] r_q;

        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                v_q <= 1'b0;
                t_q <= '0;
                p_q <= '0;
                d_q <= '0;
                r_q <= '0;
            end else if (wr_en && wr_idx == IDXW'(g)) begin
                v_q <= 1'b1;
                t_q <= wr_tag;
                p_q <= wr_present;
                d_q <= wr_dirty;
                r_q <= wr_ref;
            end
        end

        assign valid_w[g] = v_q;
        assign tag_w[g]   = t_q;
        assign pres_w[g]  = p_q;
        assign dirty_w[g] = d_q;
        assign ref_w[g]   = r_q;
    end

    assign rd_valid   = valid_w[rd_idx];
    assign rd_tag     = tag_w[rd_idx];
    assign rd_present = pres_w[rd_idx];
    assign rd_dirty   = dirty_w[rd_idx];
    assign rd_ref     = ref_w[rd_idx];

endmodule

// File: rtl/sdm_quad_pick.sv
module sdm_quad_pick #(
    parameter int QUADS = 4,
    localparam int QIW  = (QUADS > 1) ? $clog2(QUADS) : 1
) (
    input  logic [QUADS-1:0] mask,
    output logic             any,
    output logic [QIW-1:0]   idx
);

    // lowest set bit wins so write-backs leave in ascending quad order
    always_comb begin
        idx = '0;
        for (int i = QUADS - 1; i >= 0; i--) begin
            if (mask[i]) idx = QIW'(i);
        end
    end

    assign any = |mask;

endmodule

// File: rtl/sdm_stat_bank.sv
module sdm_stat_bank #(
    parameter int NUM   = 9,
    parameter int CNT_W = 32,
    parameter int SELW  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM-1:0]   inc,
    input  logic [SELW-1:0]  sel,
    output logic [CNT_W-1:0] value
);

    logic [NUM-1:0][CNT_W-1:0] cnt_w;

    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        logic [CNT_W-1:0] c_q;

        always_ff @(posedge clk) begin
            if (!rst_n)
                c_q <= '0;
            else if (inc[g] && c_q != {CNT_W{1'b1}})
                c_q <= c_q + CNT_W'(1);
        end

        assign cnt_w[g] = c_q;
    end

    always_comb begin
        value = '0;
        for (int i = 0; i < NUM; i++) begin
            if (sel == SELW'(i)) value = cnt_w[i];
        end
    end

endmodule

// File: rtl/sdm_cache_ctl.sv
module sdm_cache_ctl
    import sdm_pkg::*;
#(
    parameter int LINES = 16,
    parameter int QUADS = 4,
    parameter int WPQ   = 4,
    parameter int AW    = 24,
    parameter int CNT_W = 32,
    parameter int SELW  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_req,
    input  logic             acc_valid,
    output logic             acc_ready,
    input  logic [AW-1:0]    acc_addr,
    input  logic             acc_write,
    input  logic             acc_jump,
    output logic             rsp_valid,
    output logic [1:0]       rsp_kind,
    output logic             rsp_first_touch,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic             mem_write,
    output logic [AW-1:0]    mem_addr,
    input  logic [SELW-1:0]  stat_sel,
    output logic [CNT_W-1:0] stat_value
);

    localparam int WPL  = QUADS * WPQ;
    localparam int WQW  = $clog2(WPQ);
    localparam int QIW  = (QUADS > 1) ? $clog2(QUADS) : 1;
    localparam int OFFW = $clog2(WPL);
    localparam int IDXW = $clog2(LINES);
    localparam int TAGW = AW - OFFW - IDXW;

    sdm_state_e state_q, state_d;

    logic [AW-1:0]    a_addr_q;
    logic             a_write_q;
    logic             a_jump_q;
    logic [QUADS-1:0] wb_mask_q;
    logic [1:0]       kind_q;
    logic             rsp_valid_q;
    logic [1:0]       rsp_kind_q;
    logic             rsp_first_q;

    logic [TAGW-1:0]  a_tag;
    logic [IDXW-1:0]  a_idx;
    logic [QIW-1:0]   a_quad;

    logic             rd_valid;
    logic [TAGW-1:0]  rd_tag;
    logic [QUADS-1:0] rd_present, rd_dirty, rd_ref;

    logic             line_hit, quad_hit;
    logic [1:0]       lk_kind, cm_kind;
    logic             commit, cm_first;
    logic [QUADS-1:0] qmask;
    logic [TAGW-1:0]  wr_tag;
    logic [QUADS-1:0] wr_present, wr_dirty, wr_ref;
    logic             pick_any;
    logic [QIW-1:0]   pick_q;
    logic             flush_go;
    logic             wb_ack;
    logic [NUM_STATS-1:0] stat_inc;

    // address fields
    assign a_tag = a_addr_q[AW-1 -: TAGW];
    assign a_idx = a_addr_q[OFFW +: IDXW];
    if (QUADS > 1) begin : g_qfield
        assign a_quad = a_addr_q[WQW +: QIW];
    end else begin : g_qnone
        assign a_quad = '0;
    end

    sdm_line_store #(.LINES(LINES), .QUADS(QUADS), .TAGW(TAGW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_all  (flush_go),
        .rd_idx     (a_idx),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_present (rd_present),
        .rd_dirty   (rd_dirty),
        .rd_ref     (rd_ref),
        .wr_en      (commit),
        .wr_idx     (a_idx),
        .wr_tag     (wr_tag),
        .wr_present (wr_present),
        .wr_dirty   (wr_dirty),
        .wr_ref     (wr_ref)
    );

    sdm_quad_pick #(.QUADS(QUADS)) u_pick (
        .mask (wb_mask_q),
        .any  (pick_any),
        .idx  (pick_q)
    );

    sdm_stat_bank #(.NUM(NUM_STATS), .CNT_W(CNT_W), .SELW(SELW)) u_stats (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (stat_inc),
        .sel   (stat_sel),
        .value (stat_value)
    );

    // lookup classification and entry update
    always_comb begin
        line_hit = rd_valid && (rd_tag == a_tag);
        quad_hit = rd_present[a_quad];
        if (!line_hit)     lk_kind = KIND_LINE;
        else if (!quad_hit) lk_kind = KIND_QUAD;
        else               lk_kind = KIND_HIT;

        commit  = (state_q == ST_LOOKUP && lk_kind == KIND_HIT) ||
                  (state_q == ST_FILL && mem_ready);
        cm_kind = (state_q == ST_FILL) ? kind_q : KIND_HIT;
        qmask   = QUADS'(1) << a_quad;

        if (cm_kind == KIND_LINE) begin
            wr_tag     = a_tag;
            wr_present = qmask;
            wr_dirty   = a_write_q ? qmask : '0;
            wr_ref     = qmask;
            cm_first   = 1'b1;
        end else begin
            wr_tag     = rd_tag;
            wr_present = rd_present | qmask;
            wr_dirty   = rd_dirty | (a_write_q ? qmask : '0);
            wr_ref     = rd_ref | qmask;
            cm_first   = !rd_ref[a_quad];
        end
    end

    assign flush_go = (state_q == ST_IDLE) && flush_req;
    assign wb_ack   = (state_q == ST_WRITEBACK) && pick_any && mem_ready;

    // event counters: per-access events are counted in ST_LOOKUP
    always_comb begin
        stat_inc = '0;
        if (state_q == ST_LOOKUP) begin
            stat_inc[ST_PROBE]  = 1'b1;
            stat_inc[ST_READ]   = !a_write_q;
            stat_inc[ST_WRITE]  = a_write_q;
            stat_inc[ST_WMISS]  = a_write_q && (lk_kind != KIND_HIT);
            stat_inc[ST_WCLEAN] = a_write_q && (!line_hit || !rd_dirty[a_quad]);
            stat_inc[ST_QMISS]  = (lk_kind == KIND_QUAD);
            stat_inc[ST_LMISS]  = (lk_kind == KIND_LINE);
            stat_inc[ST_JMISS]  = a_jump_q && (lk_kind != KIND_HIT);
        end
        stat_inc[ST_WBACK] = wb_ack;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (acc_valid && acc_ready) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                unique case (lk_kind)
                    KIND_LINE: state_d = ST_WRITEBACK;
                    KIND_QUAD: state_d = ST_FILL;
                    default:   state_d = ST_IDLE;
                endcase
            end
            ST_WRITEBACK: if (!pick_any) state_d = ST_FILL;
            ST_FILL:      if (mem_ready) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // access context, write-back mask and response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_addr_q    <= '0;
            a_write_q   <= 1'b0;
            a_jump_q    <= 1'b0;
            wb_mask_q   <= '0;
            kind_q      <= KIND_HIT;
            rsp_valid_q <= 1'b0;
            rsp_kind_q  <= KIND_HIT;
            rsp_first_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && acc_valid && acc_ready) begin
                a_addr_q  <= acc_addr;
                a_write_q <= acc_write;
                a_jump_q  <= acc_jump;
            end
            if (state_q == ST_LOOKUP) begin
                kind_q    <= lk_kind;
                wb_mask_q <= line_hit ? '0 : rd_dirty;
            end else if (wb_ack) begin
                wb_mask_q <= wb_mask_q & ~(QUADS'(1) << pick_q);
            end
            rsp_valid_q <= commit;
            if (commit) begin
                rsp_kind_q  <= cm_kind;
                rsp_first_q <= cm_first;
            end
        end
    end

    // outputs
    always_comb begin
        acc_ready = (state_q == ST_IDLE) && !flush_req;
        mem_valid = ((state_q == ST_WRITEBACK) && pick_any) || (state_q == ST_FILL);
        mem_write = (state_q == ST_WRITEBACK);
        if (state_q == ST_WRITEBACK)
            mem_addr = (AW'({rd_tag, a_idx}) << OFFW) | (AW'(pick_q) << WQW);
        else
            mem_addr = a_addr_q;
        rsp_valid       = rsp_valid_q;
        rsp_kind        = rsp_kind_q;
        rsp_first_touch = rsp_first_q;
    end

endmodule

// File: rtl/sdm_cache_ctl_chk.sv
module sdm_cache_ctl_chk #(
    parameter int AW    = 24,
    parameter int CNT_W = 32,
    parameter int SELW  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_req,
    input logic             acc_ready,
    input logic             rsp_valid,
    input logic [1:0]       rsp_kind,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic             mem_write,
    input logic [AW-1:0]    mem_addr,
    input logic [SELW-1:0]  stat_sel,
    input logic [CNT_W-1:0] stat_value
);

    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !acc_ready);

    assert_wb_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && mem_ready) |=>
            (!(mem_valid && mem_write) || (mem_addr > $past(mem_addr))));

    assert_single_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_write && mem_ready) |=> !mem_valid);

    assert_flush_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !acc_ready);

    assert_rsp_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_kind != 2'd3));

    assert_cnt_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(stat_sel) |-> (stat_value >= $past(stat_value)));

endmodule

bind sdm_cache_ctl sdm_cache_ctl_chk #(.AW(AW), .CNT_W(CNT_W), .SELW(SELW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_req  (flush_req),
    .acc_ready  (acc_ready),
    .rsp_valid  (rsp_valid),
    .rsp_kind   (rsp_kind),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .stat_sel   (stat_sel),
    .stat_value (stat_value)
);

// File: tb/sdm_cache_ctl_tb.sv
`timescale 1ns/1ps
module sdm_cache_ctl_tb;

    localparam int LINES = 4;
    localparam int QUADS = 4;
    localparam int WPQ   = 2;
    localparam int AW    = 12;
    localparam int CNT_W = 8;
    localparam int SELW  = 4;
    localparam int WQW   = $clog2(WPQ);
    localparam int OFFW  = $clog2(QUADS * WPQ);
    localparam int IDXW  = $clog2(LINES);
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             flush_req = 1'b0;
    logic             acc_valid = 1'b0;
    logic             acc_ready;
    logic [AW-1:0]    acc_addr = '0;
    logic             acc_write = 1'b0;
    logic             acc_jump = 1'b0;
    logic             rsp_valid;
    logic [1:0]       rsp_kind;
    logic             rsp_first_touch;
    logic             mem_valid;
    logic             mem_ready = 1'b0;
    logic             mem_write;
    logic [AW-1:0]    mem_addr;
    logic [SELW-1:0]  stat_sel = '0;
    logic [CNT_W-1:0] stat_value;

    sdm_cache_ctl #(.LINES(LINES), .QUADS(QUADS), .WPQ(WPQ), .AW(AW),
                    .CNT_W(CNT_W), .SELW(SELW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_jump(acc_jump),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_first_touch(rsp_first_touch),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .stat_sel(stat_sel), .stat_value(stat_value)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // reference model
    bit               m_valid [LINES];
    int               m_tag   [LINES];
    bit [QUADS-1:0]   m_pres  [LINES];
    bit [QUADS-1:0]   m_dirty [LINES];
    bit [QUADS-1:0]   m_ref   [LINES];
    longint           m_cnt   [9];
    bit               e_wr    [256];
    int               e_addr  [256];
    int               e_head = 0;
    int               e_tail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat(input longint v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic model_clear(input bit counters);
        for (int i = 0; i < LINES; i++) begin
            m_valid[i] = 0; m_tag[i] = 0;
            m_pres[i] = '0; m_dirty[i] = '0; m_ref[i] = '0;
        end
        if (counters) for (int i = 0; i < 9; i++) m_cnt[i] = 0;
    endtask

    task automatic push_cmd(input bit wr, input int addr);
        e_wr[e_tail % 256]   = wr;
        e_addr[e_tail % 256] = addr;
        e_tail++;
    endtask

    task automatic predict(input int addr, input bit wr, input bit jmp,
                           output int kind, output bit first);
        int idx, tag, q;
        idx = (addr >> OFFW) & (LINES - 1);
        tag = addr >> (OFFW + IDXW);
        q   = (addr >> WQW) & (QUADS - 1);
        m_cnt[0]++;
        if (wr) m_cnt[2]++; else m_cnt[1]++;
        if (!m_valid[idx] || m_tag[idx] != tag) begin
            kind = 2;
            for (int qq = 0; qq < QUADS; qq++) begin
                if (m_dirty[idx][qq]) begin
                    push_cmd(1'b1, (m_tag[idx] << (OFFW + IDXW)) | (idx << OFFW) | (qq << WQW));
                    m_cnt[8]++;
                end
            end
            push_cmd(1'b0, addr);
            m_cnt[6]++;
            m_valid[idx] = 1; m_tag[idx] = tag;
            m_pres[idx] = '0; m_pres[idx][q] = 1'b1;
            m_dirty[idx] = '0; m_ref[idx] = '0;
        end else if (!m_pres[idx][q]) begin
            kind = 1;
            push_cmd(1'b0, addr);
            m_cnt[5]++;
            m_pres[idx][q] = 1'b1;
        end else begin
            kind = 0;
        end
        if (kind != 0) begin
            if (wr)  m_cnt[3]++;
            if (jmp) m_cnt[7]++;
        end
        first = !m_ref[idx][q];
        m_ref[idx][q] = 1'b1;
        if (wr) begin
            if (!m_dirty[idx][q]) m_cnt[4]++;
            m_dirty[idx][q] = 1'b1;
        end
    endtask

    // memory responder with random stalls; checks each accepted command
    always @(negedge clk) begin
        if (mem_valid && ($urandom_range(0, 2) != 0)) begin
            if (e_head == e_tail) begin
                chk(1'b0, "R8", "unexpected memory command", longint'(mem_addr), -1);
            end else begin
                chk(mem_write == e_wr[e_head % 256] && int'(mem_addr) == e_addr[e_head % 256],
                    e_wr[e_head % 256] ? "R4" : "R3", "memory command {write,addr}",
                    (longint'(mem_write) << 16) | longint'(mem_addr),
                    (longint'(e_wr[e_head % 256]) << 16) | longint'(e_addr[e_head % 256]));
                e_head++;
            end
            mem_ready <= 1'b1;
        end else begin
            mem_ready <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic access(input int addr, input bit wr, input bit jmp, input string req);
        int ek;
        bit ef;
        int w;
        predict(addr, wr, jmp, ek, ef);
        @(negedge clk);
        w = 0;
        while (!acc_ready && w < 1000) begin @(negedge clk); w++; end
        acc_valid = 1'b1; acc_addr = AW'(addr); acc_write = wr; acc_jump = jmp;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(acc_ready == 1'b0, "R8", "ready low after accept", acc_ready, 0);
        w = 0;
        while (!rsp_valid && w < 1000) begin @(negedge clk); w++; end
        chk(rsp_kind == 2'(ek), req, "response kind", rsp_kind, ek);
        chk(rsp_first_touch == ef, "R7", "first touch", rsp_first_touch, ef);
        chk(e_head == e_tail, "R4", "memory commands issued", e_head, e_tail);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R13", "response pulse width", rsp_valid, 0);
    endtask

    task automatic check_stats(input string req);
        for (int s = 0; s < 10; s++) begin
            stat_sel = SELW'(s);
            #1;
            chk(longint'(stat_value) == ((s < 9) ? sat(m_cnt[s]) : 0), req,
                $sformatf("counter %0d", s), longint'(stat_value),
                (s < 9) ? sat(m_cnt[s]) : 0);
        end
        stat_sel = '0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        while (!acc_ready) @(negedge clk);
        flush_req = 1'b1;
        #1;
        chk(acc_ready == 1'b0, "R11", "ready low during flush", acc_ready, 0);
        @(negedge clk);
        flush_req = 1'b0;
        model_clear(1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear(1'b1);
        e_head = 0; e_tail = 0;
    endtask

    function automatic int mk(input int tag, input int idx, input int q, input int w);
        return (tag << (OFFW + IDXW)) | (idx << OFFW) | (q << WQW) | w;
    endfunction

    initial begin
        void'($urandom(32'd4711));
        model_clear(1'b1);
        do_reset();
        @(negedge clk);
        // R12: reset state
        chk(acc_ready == 1'b1, "R12", "ready after reset", acc_ready, 1);
        chk(mem_valid == 1'b0, "R12", "mem idle after reset", mem_valid, 0);
        chk(rsp_valid == 1'b0, "R12", "no response after reset", rsp_valid, 0);
        check_stats("R12");

        // directed corner cases
        access(mk(0, 0, 0, 0), 0, 0, "R4");   // cold line miss
        access(mk(0, 0, 0, 1), 0, 0, "R2");   // hit same quad
        access(mk(0, 0, 2, 0), 0, 0, "R3");   // quad miss
        access(mk(0, 0, 1, 0), 1, 0, "R6");   // write quad miss allocates
        access(mk(0, 0, 0, 1), 1, 0, "R2");   // write hit dirties q0
        access(mk(0, 0, 3, 0), 1, 1, "R6");   // write quad miss, jump
        access(mk(1, 0, 0, 1), 0, 1, "R4");   // conflict: write-back q0,q1,q3
        access(mk(1, 0, 0, 0), 0, 0, "R2");
        access(mk(1, 0, 1, 0), 0, 0, "R5");   // q1 not present after replace
        access(mk(0, 1, 0, 0), 0, 0, "R1");   // other index: line miss
        access(mk(1, 0, 2, 1), 0, 0, "R1");   // index 0 untouched: quad miss
        access(mk(0, 1, 0, 1), 0, 0, "R1");   // index 1 hit
        access(mk(2, 2, 1, 0), 1, 0, "R6");
        check_stats("R9");
        do_flush();
        access(mk(2, 2, 1, 0), 0, 0, "R11");  // line miss, no write-back
        check_stats("R11");

        // seeded random mix
        for (int n = 0; n < 320; n++) begin
            if ($urandom_range(0, 39) == 0) do_flush();
            access($urandom_range(0, 4 * LINES * QUADS * WPQ - 1),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0), "R1");
        end
        check_stats("R10");

        do_reset();
        @(negedge clk);
        check_stats("R12");
        access(mk(0, 0, 0, 0), 0, 0, "R12");  // lines invalid after reset

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule